// File: doc/BRIEF.md
# Serial Relay Channel Select Controller

This block steers an external chain of serial-in, parallel-out shift registers that hold two bits for each relay channel, up to sixteen channels. It produces the chain's shift clock, serial data, active-low clear and output latch clock. Every clock pulse is preceded by a programmable setup interval and held high for the same number of system cycles. A new value reaches the relay outputs only through the final latch pulse of a command.

A channel is chosen by walking a two-bit marker along the chain. The controller remembers where the marker sits: zero means all channels off, and 1 to NUM_CH name a channel. It therefore shifts only the pairs needed to reach the target. If the target lies below the current channel, the marker is first pushed off the far end of the chain and then seeded again. Other commands switch everything off, clear the chain to its high-impedance state, or shift in a raw word. A single-cycle done pulse reports that a command has finished.

Top module: `relay_chain_ctrl`

## Requirements
- R1: While reset is asserted, sr_clr_n is 1, sr_clk and latch_clk are 0 and pol is 1. After release, without any command, the block shifts NUM_CH+1 pairs (each a 1 then a 0), pulses latch_clk once, shows cur_pos = 0 and pulses done.
- R2: One step is two shift pulses: data 1 and then data 0. When a select (cmd_op = 0) targets channel N with 0 < cur_pos <= N, the block shifts exactly N − cur_pos steps, and cur_pos becomes N.
- R3: When a select targets channel N while cur_pos = 0, the block seeds the marker by shifting a 0 and then a 1. It then shifts N − 1 steps, and cur_pos becomes N.
- R4: When a select targets channel N with N < cur_pos, the block first shifts NUM_CH+1 − cur_pos steps. It then seeds, shifts N − 1 steps, and cur_pos becomes N.
- R5: Every select, raw load and high-impedance command, and every all-off that starts from a nonzero position, ends with exactly one latch_clk pulse. No shift pulse follows that latch pulse. While busy is low, both clocks are low and sr_clr_n is high.
- R6: All-off (cmd_op = 1) with cur_pos ≠ 0 shifts NUM_CH+1 − cur_pos steps and latches, leaving cur_pos = 0. With cur_pos = 0 it gives no pulse at all and raises done within two cycles of acceptance.
- R7: High-impedance (cmd_op = 2) gives one shift pulse with sr_clr_n low and then one latch pulse. It leaves cur_pos and pol unchanged.
- R8: Raw load (cmd_op = 3) gives one clear pulse, as in R7, first. It then shifts min(cmd_nbits, RAW_W) bits of cmd_bits, bit 0 first, and latches. cur_pos is unchanged.
- R9: pol takes cmd_pol (0 anodic, 1 cathodic) when a select or raw load completes. All-off and high-impedance leave it unchanged.
- R10: A command is accepted when cmd_valid is high and busy is low. busy stays high until the command ends, cmd_valid is ignored while busy is high, and done is a one-cycle pulse in the first cycle with busy low again.
- R11: A select whose cmd_ch is 0 or greater than NUM_CH is ignored. busy stays low, no pulse is produced and cur_pos keeps its value.
- R12: Each sr_clk and latch_clk pulse is high for exactly HALF_CYC cycles. sr_data and sr_clr_n are stable while a clock is high, and the two clocks are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 select, 1 all-off, 2 high-impedance, 3 raw load |
| cmd_ch | input | PW (5) | Target channel for select |
| cmd_pol | input | 1 | Polarity for select or raw load, 0 anodic, 1 cathodic |
| cmd_bits | input | RAW_W (32) | Raw word, bit 0 shifted first |
| cmd_nbits | input | NBW (6) | Raw bit count, capped at RAW_W |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_pos | output | PW (5) | Marker position, 0 = all off |
| pol | output | 1 | Polarity register |
| sr_clk | output | 1 | Chain shift clock |
| sr_data | output | 1 | Chain serial data |
| sr_clr_n | output | 1 | Chain clear, active low |
| latch_clk | output | 1 | Chain output latch clock |

## Verification
The assertions assume that a command presented while busy is high has no effect. They also assume that the inputs for the chain have no path back into the block, so the only behaviour to check is what appears on the pins. The stimulus raises cmd_valid only at falling clock edges and holds the command fields steady during the accepting cycle. It deliberately presents one command during busy to show that it is dropped. Channel numbers stay within what cmd_ch can carry, including the values 0 and NUM_CH+1 that must be refused.

// File: rtl/relay_chain_pkg.sv
package relay_chain_pkg;

    typedef enum logic [1:0] {
        OP_SELECT  = 2'd0,
        OP_ALL_OFF = 2'd1,
        OP_HIZ     = 2'd2,
        OP_RAW     = 2'd3
    } relay_op_e;

    typedef enum logic {
        PULSE_SHIFT = 1'b0,
        PULSE_LATCH = 1'b1
    } pulse_kind_e;

    typedef struct packed {
        pulse_kind_e kind;
        logic        data;
        logic        clr_n;
    } pulse_req_t;

    // Pulses needed to walk the marker off the far end of the chain.
    function automatic int flush_pulses(int pos, int n_pos);
        return 2 * (n_pos - pos);
    endfunction

endpackage

// File: rtl/relay_pulse_gen.sv
module relay_pulse_gen
    import relay_chain_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  pulse_req_t req,
    output logic       busy,
    output logic       done,
    output logic       sr_clk,
    output logic       sr_data,
    output logic       sr_clr_n,
    output logic       latch_clk
);
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef enum logic [1:0] {PG_IDLE, PG_SETUP, PG_HIGH} pg_state_e;

    pg_state_e   st;
    logic [TW-1:0] tmr;
    pulse_kind_e kind;

    assign busy = (st != PG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PG_IDLE;
            tmr       <= '0;
            kind      <= PULSE_SHIFT;
            sr_data   <= 1'b0;
            sr_clr_n  <= 1'b1;
            sr_clk    <= 1'b0;
            latch_clk <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                PG_IDLE: begin
                    if (start) begin
                        kind     <= req.kind;
                        sr_data  <= req.data;
                        sr_clr_n <= req.clr_n;
                        tmr      <= TW'(HALF_CYC - 1);
                        st       <= PG_SETUP;
                    end
                end
                PG_SETUP: begin
                    if (tmr == '0) begin
                        tmr       <= TW'(HALF_CYC - 1);
                        sr_clk    <= (kind == PULSE_SHIFT);
                        latch_clk <= (kind == PULSE_LATCH);
                        st        <= PG_HIGH;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                PG_HIGH: begin
                    if (tmr == '0) begin
                        sr_clk    <= 1'b0;
                        latch_clk <= 1'b0;
                        sr_clr_n  <= 1'b1;
                        done      <= 1'b1;
                        st        <= PG_IDLE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: st <= PG_IDLE;
            endcase
        end
    end

    // R12: the two chain clocks never overlap
    p_clocks_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        !(sr_clk && latch_clk));

    // R12: data and clear hold steady across a high clock phase
    p_data_steady_r12: assert property (@(posedge clk) disable iff (rst)
        (sr_clk || latch_clk) |-> ($stable(sr_data) && $stable(sr_clr_n)));

    // R7: clear is only ever driven low together with a shift pulse, never a latch
    p_clear_no_latch_r7: assert property (@(posedge clk) disable iff (rst)
        !sr_clr_n |-> !latch_clk);

endmodule

// File: rtl/relay_chain_ctrl.sv
module relay_chain_ctrl
    import relay_chain_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int RAW_W    = 32,
    parameter int HALF_CYC = 2,
    localparam int NPOS    = NUM_CH + 1,
    localparam int PW      = $clog2(NPOS),
    localparam int NBW     = $clog2(RAW_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [PW-1:0]    cmd_ch,
    input  logic             cmd_pol,
    input  logic [RAW_W-1:0] cmd_bits,
    input  logic [NBW-1:0]   cmd_nbits,
    output logic             busy,
    output logic             done,
    output logic [PW-1:0]    cur_pos,
    output logic             pol,
    output logic             sr_clk,
    output logic             sr_data,
    output logic             sr_clr_n,
    output logic             latch_clk
);
    localparam int CW = $clog2(2 * NPOS + RAW_W + 1);

    // remaining pulses per phase, issued in this priority order
    logic             n_clear;
    logic [CW-1:0]    n_flush;
    logic [1:0]       n_seed;
    logic [CW-1:0]    n_step;
    logic [CW-1:0]    n_raw;
    logic             n_latch;
    logic [RAW_W-1:0] raw_word;
    logic             wait_pg;
    logic             upd_pos, upd_pol, next_pol;
    logic [PW-1:0]    next_pos;

    // plan computed for the command at the port
    logic             p_clear, p_latch, p_updpos, p_updpol;
    logic [CW-1:0]    p_flush, p_step, p_raw;
    logic [1:0]       p_seed;
    logic             ch_ok, accept;

    logic             pg_start, pg_busy, pg_done, any_left, finish;
    pulse_req_t       pg_req;

    assign ch_ok  = (cmd_ch != '0) && (int'(cmd_ch) <= NUM_CH);
    assign accept = cmd_valid && !busy &&
                    ((relay_op_e'(cmd_op) != OP_SELECT) || ch_ok);

    always_comb begin
        int pos_i, tgt_i, nb_i;
        pos_i    = int'(cur_pos);
        tgt_i    = int'(cmd_ch);
        nb_i     = int'(cmd_nbits);
        if (nb_i > RAW_W) nb_i = RAW_W;
        p_clear  = 1'b0;
        p_flush  = '0;
        p_seed   = '0;
        p_step   = '0;
        p_raw    = '0;
        p_latch  = 1'b0;
        p_updpos = 1'b0;
        p_updpol = 1'b0;
        case (relay_op_e'(cmd_op))
            OP_SELECT: begin
                if (pos_i != 0 && tgt_i < pos_i) begin
                    p_flush = CW'(flush_pulses(pos_i, NPOS));
                    pos_i   = 0;
                end
                if (pos_i == 0) begin
                    p_seed = 2'd2;
                    p_step = CW'(2 * (tgt_i - 1));
                end else begin
                    p_step = CW'(2 * (tgt_i - pos_i));
                end
                p_latch  = 1'b1;
                p_updpos = 1'b1;
                p_updpol = 1'b1;
            end
            OP_ALL_OFF: begin
                if (pos_i != 0) begin
                    p_flush = CW'(flush_pulses(pos_i, NPOS));
                    p_latch = 1'b1;
                end
                p_updpos = 1'b1;
            end
            OP_HIZ: begin
                p_clear = 1'b1;
                p_latch = 1'b1;
            end
            default: begin
                p_clear  = 1'b1;
                p_raw    = CW'(nb_i);
                p_latch  = 1'b1;
                p_updpol = 1'b1;
            end
        endcase
    end

    assign any_left = n_clear || n_latch || (n_flush != '0) || (n_seed != '0) ||
                      (n_step != '0) || (n_raw != '0);
    assign pg_start = busy && !wait_pg && !pg_busy && any_left;
    assign finish   = busy && !wait_pg && !pg_busy && !any_left;

    always_comb begin
        pg_req = '{kind: PULSE_SHIFT, data: 1'b0, clr_n: 1'b1};
        if (n_clear)               pg_req.clr_n = 1'b0;
        else if (n_flush != '0)    pg_req.data  = ~n_flush[0];
        else if (n_seed != '0)     pg_req.data  = (n_seed == 2'd1);
        else if (n_step != '0)     pg_req.data  = ~n_step[0];
        else if (n_raw != '0)      pg_req.data  = raw_word[0];
        else                       pg_req.kind  = PULSE_LATCH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            cur_pos  <= '0;
            pol      <= 1'b1;
            n_clear  <= 1'b0;
            n_flush  <= CW'(2 * NPOS);
            n_seed   <= '0;
            n_step   <= '0;
            n_raw    <= '0;
            n_latch  <= 1'b1;
            raw_word <= '0;
            wait_pg  <= 1'b0;
            upd_pos  <= 1'b1;
            upd_pol  <= 1'b0;
            next_pos <= '0;
            next_pol <= 1'b1;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                n_clear  <= p_clear;
                n_flush  <= p_flush;
                n_seed   <= p_seed;
                n_step   <= p_step;
                n_raw    <= p_raw;
                n_latch  <= p_latch;
                raw_word <= cmd_bits;
                upd_pos  <= p_updpos;
                upd_pol  <= p_updpol;
                next_pos <= (relay_op_e'(cmd_op) == OP_SELECT) ? cmd_ch : '0;
                next_pol <= cmd_pol;
            end
            if (pg_start) begin
                wait_pg <= 1'b1;
                if (n_clear)            n_clear <= 1'b0;
                else if (n_flush != '0) n_flush <= n_flush - 1'b1;
                else if (n_seed != '0)  n_seed  <= n_seed - 1'b1;
                else if (n_step != '0)  n_step  <= n_step - 1'b1;
                else if (n_raw != '0) begin
                    n_raw    <= n_raw - 1'b1;
                    raw_word <= raw_word >> 1;
                end
                else                    n_latch <= 1'b0;
            end else if (pg_done) begin
                wait_pg <= 1'b0;
            end
            if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
                if (upd_pos) cur_pos <= next_pos;
                if (upd_pol) pol     <= next_pol;
            end
        end
    end

    relay_pulse_gen #(.HALF_CYC(HALF_CYC)) i_pulse (
        .clk       (clk),
        .rst       (rst),
        .start     (pg_start),
        .req       (pg_req),
        .busy      (pg_busy),
        .done      (pg_done),
        .sr_clk    (sr_clk),
        .sr_data   (sr_data),
        .sr_clr_n  (sr_clr_n),
        .latch_clk (latch_clk)
    );

    // R2: the tracked position never leaves 0..NUM_CH
    p_pos_range_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cur_pos) <= NUM_CH);

    // R10: done appears only as busy falls
    p_done_follows_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R9: polarity never moves in the middle of a command
    p_pol_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(pol));

    // R5: chain pins rest while idle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sr_clk && !latch_clk && sr_clr_n));

    // R10: a busy controller keeps its position while a command runs
    p_pos_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_pos));

endmodule

// File: tb/test_relay_chain_ctrl.sv
module test_relay_chain_ctrl;
    import relay_chain_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_CYC   = 2;
    localparam int NUM_CH     = 16;
    localparam int NPOS       = NUM_CH + 1;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  ch;
        logic        cpol;
        logic [31:0] bits;
        logic [5:0]  nbits;
        logic [7:0]  exp_shifts;
        logic [4:0]  exp_pos;
        logic        exp_pol;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 5'd3,  1'b0, 32'h0,         6'd0,  8'd6,  5'd3,  1'b0},
        '{2'd0, 5'd7,  1'b1, 32'h0,         6'd0,  8'd8,  5'd7,  1'b1},
        '{2'd0, 5'd7,  1'b0, 32'h0,         6'd0,  8'd0,  5'd7,  1'b0},
        '{2'd0, 5'd2,  1'b1, 32'h0,         6'd0,  8'd24, 5'd2,  1'b1},
        '{2'd0, 5'd16, 1'b0, 32'h0,         6'd0,  8'd28, 5'd16, 1'b0},
        '{2'd1, 5'd0,  1'b1, 32'h0,         6'd0,  8'd2,  5'd0,  1'b0},
        '{2'd1, 5'd0,  1'b1, 32'h0,         6'd0,  8'd0,  5'd0,  1'b0},
        '{2'd0, 5'd1,  1'b1, 32'h0,         6'd0,  8'd2,  5'd1,  1'b1},
        '{2'd3, 5'd0,  1'b0, 32'h000000A5,  6'd8,  8'd8,  5'd1,  1'b0},
        '{2'd2, 5'd0,  1'b1, 32'h0,         6'd0,  8'd0,  5'd1,  1'b0},
        '{2'd3, 5'd0,  1'b1, 32'h80000001,  6'd40, 8'd32, 5'd1,  1'b1},
        '{2'd0, 5'd1,  1'b0, 32'h0,         6'd0,  8'd0,  5'd1,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_ch = '0;
    logic        cmd_pol = 1'b0;
    logic [31:0] cmd_bits = '0;
    logic [5:0]  cmd_nbits = '0;
    logic        busy, done, pol, sr_clk, sr_data, sr_clr_n, latch_clk;
    logic [4:0]  cur_pos;

    int n_checks = 0;
    int n_fail   = 0;

    // pin monitor
    int          sh_cnt = 0, clr_cnt = 0, lat_cnt = 0;
    int          bad_width = 0, after_latch = 0, clr_late = 0, busy_rises = 0;
    logic [127:0] seqv = '0;
    time         rise_t = 0;
    logic        seen_rise = 1'b0;

    // bench model
    int           mpos = 0;
    logic [127:0] ev;
    int           en, ec, el;

    always #(CLK_PERIOD/2) clk = ~clk;

    relay_chain_ctrl #(.NUM_CH(NUM_CH), .RAW_W(32), .HALF_CYC(HALF_CYC)) i_relay_chain_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
        .cmd_pol(cmd_pol), .cmd_bits(cmd_bits), .cmd_nbits(cmd_nbits),
        .busy(busy), .done(done), .cur_pos(cur_pos), .pol(pol),
        .sr_clk(sr_clk), .sr_data(sr_data), .sr_clr_n(sr_clr_n), .latch_clk(latch_clk)
    );

    always @(posedge sr_clk) begin
        if (!sr_clr_n) begin
            clr_cnt++;
            if (sh_cnt != 0) clr_late++;
        end else begin
            seqv[sh_cnt] = sr_data;
            sh_cnt++;
        end
        if (lat_cnt != 0) after_latch++;
        rise_t    = $time;
        seen_rise = 1'b1;
    end

    always @(negedge sr_clk) begin
        if (seen_rise && ($time - rise_t) != HALF_CYC * CLK_PERIOD) bad_width++;
        seen_rise = 1'b0;
    end

    always @(posedge latch_clk) lat_cnt++;
    always @(posedge busy) busy_rises++;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        sh_cnt = 0; clr_cnt = 0; lat_cnt = 0; bad_width = 0;
        after_latch = 0; clr_late = 0; busy_rises = 0; seqv = '0;
    endtask

    task automatic add_bit(input logic b);
        ev[en] = b;
        en++;
    endtask

    // expected pins and position from the requirements
    task automatic model(input int op, input int ch, input logic [31:0] bits, input int nb);
        ev = '0; en = 0; ec = 0; el = 0;
        case (op)
            0: begin
                if (mpos != 0 && ch < mpos) begin
                    for (int i = 0; i < NPOS - mpos; i++) begin add_bit(1); add_bit(0); end
                    mpos = 0;
                end
                if (mpos == 0) begin
                    add_bit(0); add_bit(1);
                    for (int i = 0; i < ch - 1; i++) begin add_bit(1); add_bit(0); end
                end else begin
                    for (int i = 0; i < ch - mpos; i++) begin add_bit(1); add_bit(0); end
                end
                mpos = ch; el = 1;
            end
            1: begin
                if (mpos != 0) begin
                    for (int i = 0; i < NPOS - mpos; i++) begin add_bit(1); add_bit(0); end
                    el = 1;
                end
                mpos = 0;
            end
            2: begin ec = 1; el = 1; end
            default: begin
                ec = 1; el = 1;
                for (int i = 0; i < ((nb > 32) ? 32 : nb); i++) add_bit(bits[i]);
            end
        endcase
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!done && cycles < 5000);
    endtask

    task automatic check_pins(input string tag);
        int mism;
        mism = 0;
        for (int i = 0; i < en; i++) if (seqv[i] !== ev[i]) mism++;
        chk(sh_cnt == en, {tag, " shift count"}, sh_cnt, en);
        chk(mism == 0, {tag, " serial bits"}, mism, 0);
        chk(clr_cnt == ec, {tag, " clear pulses R7"}, clr_cnt, ec);
        chk(clr_late == 0, {tag, " clear first R8"}, clr_late, 0);
        chk(lat_cnt == el, {tag, " latch count R5"}, lat_cnt, el);
        chk(after_latch == 0, {tag, " shift after latch R5"}, after_latch, 0);
        chk(bad_width == 0, {tag, " pulse width R12"}, bad_width, 0);
    endtask

    task automatic run_cmd(input vec_t v, input string tag);
        int cyc;
        while (busy) @(negedge clk);
        clear_mon();
        model(int'(v.op), int'(v.ch), v.bits, int'(v.nbits));
        cmd_valid = 1'b1; cmd_op = v.op; cmd_ch = v.ch; cmd_pol = v.cpol;
        cmd_bits = v.bits; cmd_nbits = v.nbits;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(cyc);
        chk(done == 1'b1, {tag, " done seen R10"}, done, 1);
        if (v.op == 2'd1 && v.exp_shifts == 0)
            chk(cyc <= 2, {tag, " immediate done R6"}, cyc, 2);
        @(negedge clk);
        chk(done == 1'b0, {tag, " done single cycle R10"}, done, 0);
        check_pins(tag);
        chk(sh_cnt == int'(v.exp_shifts), {tag, " table shifts"}, sh_cnt, v.exp_shifts);
        chk(cur_pos == v.exp_pos && int'(cur_pos) == mpos, {tag, " position"}, cur_pos, v.exp_pos);
        chk(pol == v.exp_pol, {tag, " polarity R9"}, pol, v.exp_pol);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int cyc;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset levels
        chk(sr_clr_n == 1'b1, "R1 reset clear high", sr_clr_n, 1);
        chk(sr_clk == 1'b0 && latch_clk == 1'b0, "R1 reset clocks low", sr_clk, 0);
        chk(pol == 1'b1, "R1 reset polarity cathodic", pol, 1);
        clear_mon();
        mpos = NUM_CH;
        model(1, 0, '0, 0);
        mpos = 0;
        ev = '0; en = 0; el = 1; ec = 0;
        for (int i = 0; i < NPOS; i++) begin add_bit(1); add_bit(0); end
        rst = 1'b0;
        wait_done(cyc);
        chk(done == 1'b1, "R1 automatic all-off done", done, 1);
        @(negedge clk);
        check_pins("R1 automatic all-off");
        chk(cur_pos == 0, "R1 position after start", cur_pos, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            case (k)
                0, 7:  tag = $sformatf("R3 vec%0d", k);
                1, 2:  tag = $sformatf("R2 vec%0d", k);
                3:     tag = $sformatf("R4 vec%0d", k);
                4:     tag = $sformatf("R2 vec%0d", k);
                5, 6:  tag = $sformatf("R6 vec%0d", k);
                9:     tag = $sformatf("R7 vec%0d", k);
                default: tag = $sformatf("R8 vec%0d", k);
            endcase
            run_cmd(VECS[k], tag);
        end

        // R10: a command presented while busy is dropped
        while (busy) @(negedge clk);
        clear_mon();
        model(0, 5, '0, 0);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_ch = 5'd5; cmd_pol = 1'b1;
        @(negedge clk);
        cmd_op = 2'd1; cmd_ch = 5'd0; cmd_pol = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R10 busy during command", busy, 1);
        cmd_valid = 1'b0;
        wait_done(cyc);
        @(negedge clk);
        repeat (30) @(negedge clk);
        check_pins("R10 busy drop");
        chk(cur_pos == 5, "R10 position from first command only", cur_pos, 5);
        chk(pol == 1'b1, "R10 polarity from first command only", pol, 1);
        chk(busy_rises == 1, "R10 single acceptance", busy_rises, 1);

        // R11: out-of-range selects are ignored
        for (int k = 0; k < 2; k++) begin
            clear_mon();
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_ch = (k == 0) ? 5'd0 : 5'd17; cmd_pol = 1'b0;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (20) @(negedge clk);
            chk(busy_rises == 0, "R11 no acceptance", busy_rises, 0);
            chk(sh_cnt + clr_cnt + lat_cnt == 0, "R11 no pulses", sh_cnt + clr_cnt + lat_cnt, 0);
            chk(cur_pos == 5, "R11 position kept", cur_pos, 5);
            chk(pol == 1'b1, "R11 polarity kept", pol, 1);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule